// File: doc/BRIEF.md
# Expanded RAM External Bus Decoder

This block serves the external data-move requests of an 8051-style core. Each request names an addressing mode (8-bit register-indirect or 16-bit pointer), a direction, an address and write data. The block sends the access to one of two targets. One is an on-chip expanded RAM of 768 bytes. The other is an external bus, where the low address byte shares one port with data and the high address byte has a port of its own.

The choice of target depends on three things: the mode, whether the address lies at or above the end of the on-chip RAM (0x300), and a configuration bit held in the block. When the bit is clear, pointer accesses below 0x300 and all register-indirect accesses stay on chip. Register-indirect accesses then reach only the first 256 locations. When the bit is set, every access goes out on the bus. An on-chip access finishes in one clock. An external access runs a fixed sequence: an address-latch pulse, a data phase, then an active-low read or write strobe held for `STB_CLKS` clocks. Each access ends with a one-clock done pulse and, for reads, valid read data.

Top module: `xram_bus_decoder`

## Requirements
- R1: After reset the configuration bit is 0. `rd_n` and `wr_n` are 1, and `ad_oe`, `ale` and `done` are 0. `req_ready` is 1.
- R2: With the configuration bit at 0, a pointer access (`req_wide`=1) with an address below 0x300 uses on-chip location `req_addr[9:0]`. It asserts neither strobe nor `ale`. A read returns the last byte written to that location.
- R3: With the configuration bit at 0, a pointer access with an address of 0x300 or above runs an external bus cycle.
- R4: With the configuration bit at 0, a register-indirect access (`req_wide`=0) uses on-chip location `req_addr[7:0]`. It ignores `req_addr[15:8]`, so locations 0x100 to 0x2FF are unreachable this way. It asserts no strobe.
- R5: With the configuration bit at 1, every access runs an external bus cycle, whatever its mode or address.
- R6: On an external pointer access, `ale` is high for exactly one clock, the first of the cycle, with `ad_out` = `req_addr[7:0]` and `ad_oe` = 1. `hi_oe` is 1 and `hi_addr` = `req_addr[15:8]` from that clock through the done clock.
- R7: On an external register-indirect access, `ale` carries `req_addr[7:0]` on `ad_out` as in R6, and `hi_oe` stays 0 throughout.
- R8: An external write holds `wr_n` low for exactly `STB_CLKS` clocks, from the third clock of the cycle, with `ad_oe` = 1 and `ad_out` = write data. `rd_n` stays 1.
- R9: An external read holds `rd_n` low for exactly `STB_CLKS` clocks with `ad_oe` = 0, and `wr_n` stays 1. `rdata` returns `ad_in` as sampled on the last strobe clock.
- R10: `done` is high for exactly one clock. For an on-chip access it is the clock right after the accepting edge. For an external access it is the clock `STB_CLKS`+2 clocks after that one. `rdata` is valid while `done` is high.
- R11: `req_ready` is 0 from acceptance through the done clock. A request presented while `req_ready` is 0 is ignored and does not change the on-chip RAM.
- R12: A clock with `cfg_we` = 1 loads `cfg_din` into the configuration bit, and this changes the routing of the accesses that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load enable for the configuration bit |
| cfg_din | input | 1 | New configuration bit value (1 = all accesses external) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this clock |
| req_wide | input | 1 | 1 = 16-bit pointer mode, 0 = 8-bit register-indirect |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read data, valid with done |
| ale | output | 1 | Address latch enable for the external bus |
| ad_out | output | 8 | Multiplexed low address / write data out |
| ad_oe | output | 1 | Output enable for ad_out |
| ad_in | input | 8 | Read data from the external bus |
| hi_addr | output | 8 | High address byte |
| hi_oe | output | 1 | Output enable for hi_addr |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Counting the accepting edge as edge 0, an on-chip access shows `done` and its read data in the clock that follows it. An external access shows `ale` in that same clock. Its strobe is low in clocks 2 to `STB_CLKS`+1, and `done` with read data comes in clock `STB_CLKS`+2. The bench samples every output at the falling edge of each of those clocks and compares the clock index of each event with these numbers. It changes the external read data on every strobe clock, so a sample taken on any clock other than the last strobe clock gives the wrong byte. A stray request is held during the first two clocks of an external access, and a later read-back shows it had no effect.

// File: rtl/xbd_pkg.sv
package xbd_pkg;
  parameter int unsigned XBD_AW = 16;
  parameter int unsigned XBD_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INT,
    ST_ALE,
    ST_DATA,
    ST_STB,
    ST_DONE
  } xbd_state_e;

  typedef struct packed {
    logic              wide;
    logic              write;
    logic [XBD_AW-1:0] addr;
    logic [XBD_DW-1:0] wdata;
  } xbd_req_t;
endpackage

// File: rtl/xbd_route.sv
module xbd_route #(
  parameter int unsigned XRAM_BYTES = 768,
  parameter int unsigned IW         = $clog2(XRAM_BYTES)
) (
  input  logic                      cfg_ext,
  input  logic                      wide,
  input  logic [xbd_pkg::XBD_AW-1:0] addr,
  output logic                      to_ext,
  output logic [IW-1:0]             idx
);
  import xbd_pkg::*;

  localparam logic [XBD_AW-1:0] TOP_ADDR = XBD_AW'(XRAM_BYTES);

  logic above;

  always_comb begin
    above  = (addr >= TOP_ADDR);
    to_ext = cfg_ext | (wide & above);
    if (wide) idx = addr[IW-1:0];
    else      idx = IW'(addr[XBD_DW-1:0]);
  end
endmodule

// File: rtl/xbd_xram.sv
module xbd_xram #(
  parameter int unsigned XRAM_BYTES = 768,
  parameter int unsigned IW         = $clog2(XRAM_BYTES)
) (
  input  logic                      clk,
  input  logic                      en,
  input  logic                      we,
  input  logic [IW-1:0]             idx,
  input  logic [xbd_pkg::XBD_DW-1:0] wdata,
  output logic [xbd_pkg::XBD_DW-1:0] rdata
);
  import xbd_pkg::*;

  logic [XBD_DW-1:0] mem_q [XRAM_BYTES];
  logic [XBD_DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem_q[idx] <= wdata;
      else    rd_q       <= mem_q[idx];
    end
  end

  assign rdata = rd_q;
endmodule

// File: rtl/xbd_ctrl.sv
module xbd_ctrl #(
  parameter int unsigned STB_CLKS = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_int,
  input  logic                              start_ext,
  input  xbd_pkg::xbd_req_t                 req,
  output logic                              ready,
  output logic                              done,
  output logic                              ale,
  output logic [xbd_pkg::XBD_DW-1:0]        ad_out,
  output logic                              ad_oe,
  input  logic [xbd_pkg::XBD_DW-1:0]        ad_in,
  output logic [xbd_pkg::XBD_AW-xbd_pkg::XBD_DW-1:0] hi_addr,
  output logic                              hi_oe,
  output logic                              rd_n,
  output logic                              wr_n,
  output logic [xbd_pkg::XBD_DW-1:0]        ext_rdata
);
  import xbd_pkg::*;

  localparam int unsigned CW   = (STB_CLKS > 1) ? $clog2(STB_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STB_CLKS - 1);
  localparam int unsigned HW   = XBD_AW - XBD_DW;

  xbd_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  xbd_req_t          req_q, cur;
  logic              in_ext, smp;
  logic              ale_d, ad_oe_d, hi_oe_d, rd_n_d, wr_n_d, done_d;
  logic [XBD_DW-1:0] ad_out_d;
  logic [HW-1:0]     hi_addr_d;
  logic              ale_q, ad_oe_q, hi_oe_q, rd_n_q, wr_n_q, done_q;
  logic [XBD_DW-1:0] ad_out_q, rdata_q;
  logic [HW-1:0]     hi_addr_q;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ext)      state_d = ST_ALE;
        else if (start_int) state_d = ST_INT;
      end
      ST_INT:  state_d = ST_IDLE;
      ST_ALE:  state_d = ST_DATA;
      ST_DATA: begin
        state_d = ST_STB;
        cnt_d   = '0;
      end
      ST_STB: begin
        if (cnt_q == LAST) state_d = ST_DONE;
        else               cnt_d   = cnt_q + 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // output decode from the next state, registered below
  always_comb begin
    cur       = (state_q == ST_IDLE) ? req : req_q;
    in_ext    = (state_d == ST_ALE) || (state_d == ST_DATA) ||
                (state_d == ST_STB) || (state_d == ST_DONE);
    ale_d     = (state_d == ST_ALE);
    ad_oe_d   = ale_d | (in_ext & cur.write);
    ad_out_d  = ale_d ? cur.addr[XBD_DW-1:0] : cur.wdata;
    hi_oe_d   = in_ext & cur.wide;
    hi_addr_d = cur.addr[XBD_AW-1:XBD_DW];
    rd_n_d    = !((state_d == ST_STB) && !cur.write);
    wr_n_d    = !((state_d == ST_STB) && cur.write);
    done_d    = (state_d == ST_INT) || (state_d == ST_DONE);
    smp       = (state_q == ST_STB) && (cnt_q == LAST) && !req_q.write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ale_q   <= 1'b0;
      ad_oe_q <= 1'b0;
      hi_oe_q <= 1'b0;
      rd_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ale_q   <= ale_d;
      ad_oe_q <= ad_oe_d;
      hi_oe_q <= hi_oe_d;
      rd_n_q  <= rd_n_d;
      wr_n_q  <= wr_n_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start_ext) req_q <= req;
    if (smp)       rdata_q <= ad_in;
    ad_out_q  <= ad_out_d;
    hi_addr_q <= hi_addr_d;
  end

  assign ready     = (state_q == ST_IDLE);
  assign done      = done_q;
  assign ale       = ale_q;
  assign ad_out    = ad_out_q;
  assign ad_oe     = ad_oe_q;
  assign hi_addr   = hi_addr_q;
  assign hi_oe     = hi_oe_q;
  assign rd_n      = rd_n_q;
  assign wr_n      = wr_n_q;
  assign ext_rdata = rdata_q;
endmodule

// File: rtl/xram_bus_decoder.sv
module xram_bus_decoder #(
  parameter int unsigned XRAM_BYTES = 768,
  parameter int unsigned STB_CLKS   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_din,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_wide,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        done,
  output logic [7:0]  rdata,
  output logic        ale,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  ad_in,
  output logic [7:0]  hi_addr,
  output logic        hi_oe,
  output logic        rd_n,
  output logic        wr_n
);
  import xbd_pkg::*;

  localparam int unsigned IW = $clog2(XRAM_BYTES);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              cfg_q;
  logic              accept, to_ext, start_int, start_ext, rd_src_q;
  logic [IW-1:0]     idx;
  logic [XBD_DW-1:0] ram_rdata, ext_rdata;
  xbd_req_t          req_s;

  // reset released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cfg_q    <= 1'b0;
      rd_src_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q    <= cfg_din;
      if (accept) rd_src_q <= to_ext;
    end
  end

  assign req_s     = {req_wide, req_write, req_addr, req_wdata};
  assign accept    = req_valid & req_ready;
  assign start_ext = accept & to_ext;
  assign start_int = accept & ~to_ext;

  xbd_route #(.XRAM_BYTES(XRAM_BYTES), .IW(IW)) u_route (
    .cfg_ext (cfg_q),
    .wide    (req_wide),
    .addr    (req_addr),
    .to_ext  (to_ext),
    .idx     (idx)
  );

  xbd_xram #(.XRAM_BYTES(XRAM_BYTES), .IW(IW)) u_xram (
    .clk   (clk),
    .en    (start_int),
    .we    (req_write),
    .idx   (idx),
    .wdata (req_wdata),
    .rdata (ram_rdata)
  );

  xbd_ctrl #(.STB_CLKS(STB_CLKS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_int (start_int),
    .start_ext (start_ext),
    .req       (req_s),
    .ready     (req_ready),
    .done      (done),
    .ale       (ale),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .ad_in     (ad_in),
    .hi_addr   (hi_addr),
    .hi_oe     (hi_oe),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ext_rdata (ext_rdata)
  );

  assign rdata = rd_src_q ? ext_rdata : ram_rdata;
endmodule

// File: rtl/xbd_chk.sv
module xbd_chk #(
  parameter int unsigned XRAM_BYTES = 768
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_wide,
  input logic [15:0] req_addr,
  input logic        done,
  input logic        ale,
  input logic        ad_oe,
  input logic        hi_oe,
  input logic        rd_n,
  input logic        wr_n
);
  localparam logic [15:0] TOP_ADDR = 16'(XRAM_BYTES);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R9
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R8
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  // R6
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && ad_oe));

  // R2
  int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg && (!req_wide || req_addr < TOP_ADDR))
    |=> (done && rd_n && wr_n && !ale));

  // R5
  ext_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cfg) |=> (ale && !done));

  // R7
  narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cfg && !req_wide) |=> !hi_oe);

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind xram_bus_decoder xbd_chk #(.XRAM_BYTES(XRAM_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .cfg       (cfg_q),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_wide  (req_wide),
  .req_addr  (req_addr),
  .done      (done),
  .ale       (ale),
  .ad_oe     (ad_oe),
  .hi_oe     (hi_oe),
  .rd_n      (rd_n),
  .wr_n      (wr_n)
);

// File: tb/xram_bus_decoder_bench.sv
module xram_bus_decoder_bench;
  localparam int S = 3;

  logic        clk, rst_n, cfg_we, cfg_din, req_valid, req_ready, req_wide, req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, rdata, ad_out, ad_in, hi_addr;
  logic        done, ale, ad_oe, hi_oe, rd_n, wr_n;

  int vectors = 0, fails = 0, cyc = 0;
  logic [7:0] model [768];
  bit   cfg_m;
  int   last_done_k;
  logic [7:0] last_rd;

  xram_bus_decoder #(.XRAM_BYTES(768), .STB_CLKS(S)) u_xram_bus_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_din(cfg_din),
    .req_valid(req_valid), .req_ready(req_ready), .req_wide(req_wide),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .hi_addr(hi_addr), .hi_oe(hi_oe), .rd_n(rd_n), .wr_n(wr_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual cycle %0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string rq, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] ext_byte(input logic [15:0] a, input logic w);
    return a[7:0] ^ 8'hC3 ^ (w ? a[15:8] : 8'h00);
  endfunction

  task automatic set_cfg(input bit v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_din = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_m = v;
  endtask

  task automatic access(input logic wide, input logic wr, input logic [15:0] addr,
                        input logic [7:0] wd, input bit stray);
    bit ext, bad_hi, bad_wd, bad_rel, bad_ale;
    int idx, ale_n, rd_c, wr_c, done_k, first_stb;
    logic [7:0] ale_val, got, exp_rd;
    string tg;
    ext = cfg_m || (wide && addr >= 16'h0300);
    idx = wide ? int'(addr) : int'(addr[7:0]);
    tg  = ext ? (cfg_m ? "R5" : "R3") : (wide ? "R2" : "R4");
    ale_n = 0; rd_c = 0; wr_c = 0; done_k = -1; first_stb = -1;
    bad_hi = 0; bad_wd = 0; bad_rel = 0; bad_ale = 0; ale_val = 8'h00; got = 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_wide = wide; req_write = wr; req_addr = addr; req_wdata = wd;
    chk("R11", req_ready === 1'b1, req_ready, 1);
    @(negedge clk);
    if (stray) begin
      req_wide = 1'b0; req_write = 1'b1; req_addr = 16'h0077; req_wdata = 8'hEE;
    end else req_valid = 1'b0;
    chk("R11", req_ready === 1'b0, req_ready, 0);
    for (int k = 0; k < 40; k++) begin
      if (ale) begin
        ale_n++; ale_val = ad_out;
        if (!ad_oe || k != 0) bad_ale = 1;
      end
      if (!rd_n) begin
        rd_c++; if (first_stb < 0) first_stb = k;
        if (ad_oe) bad_rel = 1;
        ad_in = ext_byte(addr, wide) ^ 8'(k);
      end else ad_in = 8'h00;
      if (!wr_n) begin
        wr_c++; if (first_stb < 0) first_stb = k;
        if (!ad_oe || ad_out !== wd) bad_wd = 1;
      end
      if (ext && wide) begin
        if (hi_oe !== 1'b1 || hi_addr !== addr[15:8]) bad_hi = 1;
      end else if (hi_oe !== 1'b0) bad_hi = 1;
      if (done) begin
        done_k = k; got = rdata;
        break;
      end
      if (k == 1) req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    ad_in = 8'h00;
    last_done_k = done_k;
    last_rd = got;
    chk("R10", done_k == (ext ? S + 2 : 0), done_k, ext ? S + 2 : 0);
    if (ext) begin
      chk(wide ? "R6" : "R7", ale_n == 1 && !bad_ale && ale_val === addr[7:0], ale_val, addr[7:0]);
      chk(wide ? "R6" : "R7", !bad_hi, hi_oe, wide);
      if (wr) begin
        chk("R8", wr_c == S && rd_c == 0 && !bad_wd && first_stb == 2, wr_c, S);
      end else begin
        exp_rd = ext_byte(addr, wide) ^ 8'(S + 1);
        chk("R9", rd_c == S && wr_c == 0 && !bad_rel && first_stb == 2, rd_c, S);
        chk("R9", got === exp_rd, got, exp_rd);
      end
    end else begin
      chk(tg, ale_n == 0 && rd_c == 0 && wr_c == 0 && !bad_hi, rd_c + wr_c + ale_n, 0);
      if (wr) model[idx] = wd;
      else chk(tg, got === model[idx], got, model[idx]);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_din = 1'b0; req_valid = 1'b0; req_wide = 1'b0;
    req_write = 1'b0; req_addr = 16'h0; req_wdata = 8'h0; ad_in = 8'h0; cfg_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", rd_n === 1'b1 && wr_n === 1'b1, {rd_n, wr_n}, 2'b11);
    chk("R1", ad_oe === 1'b0 && ale === 1'b0 && done === 1'b0, {ad_oe, ale, done}, 0);
    chk("R1", req_ready === 1'b1, req_ready, 1);
    access(1'b1, 1'b0, 16'h0010, 8'h00, 1'b0);
    chk("R1", last_done_k == 0, last_done_k, 0);

    for (int i = 0; i < 768; i++) access(1'b1, 1'b1, 16'(i), 8'(i * 7 + 3), 1'b0);

    // R2 top on-chip location and R3 first external address
    access(1'b1, 1'b0, 16'h02FF, 8'h00, 1'b0);
    access(1'b1, 1'b1, 16'h0300, 8'h5A, 1'b0);
    access(1'b1, 1'b0, 16'h0300, 8'h00, 1'b0);
    access(1'b1, 1'b0, 16'hFFFF, 8'h00, 1'b0);
    // R4 narrow ignores high byte: writes 0x0AB, leaves 0x1AB
    access(1'b0, 1'b1, 16'h01AB, 8'h99, 1'b0);
    access(1'b1, 1'b0, 16'h00AB, 8'h00, 1'b0);
    chk("R4", last_rd === 8'h99, last_rd, 8'h99);
    access(1'b1, 1'b0, 16'h01AB, 8'h00, 1'b0);
    chk("R4", last_rd === model[16'h01AB], last_rd, model[16'h01AB]);
    // R11 stray request during an external access
    access(1'b1, 1'b1, 16'h8001, 8'h3C, 1'b1);
    access(1'b0, 1'b0, 16'h0077, 8'h00, 1'b0);
    chk("R11", last_rd === model[16'h0077], last_rd, model[16'h0077]);
    // R12 config bit routes low addresses outward, then back
    set_cfg(1'b1);
    access(1'b1, 1'b0, 16'h0010, 8'h00, 1'b0);
    chk("R12", last_done_k == S + 2, last_done_k, S + 2);
    access(1'b0, 1'b1, 16'h1234, 8'hA5, 1'b0);
    access(1'b0, 1'b0, 16'h0042, 8'h00, 1'b0);
    set_cfg(1'b0);
    access(1'b1, 1'b0, 16'h0010, 8'h00, 1'b0);
    chk("R12", last_done_k == 0, last_done_k, 0);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      logic [15:0] a;
      r = $urandom;
      if (r[2:0] == 3'd0) set_cfg(r[3]);
      case (r[5:4])
        2'd0, 2'd1: a = 16'($urandom % 768);
        2'd2:       a = 16'h02F0 + 16'($urandom % 32);
        default:    a = 16'($urandom);
      endcase
      access(r[6], r[7], a, r[15:8], 1'b0);
    end
    finish_run();
  end
endmodule